// File: doc/BRIEF.md
# Operate Micro-Instruction Executor

This block carries out the register-only operate instructions of a 12-bit accumulator machine, one instruction per clock. It owns the link:accumulator pair, a 13-bit register made of a one-bit link above a `WORD_W`-bit accumulator. When the sequencer raises `fire` with an operate word, the block updates that register. It also reports a one-cycle `skip` pulse, which the sequencer adds to the next program counter, and it sets a sticky `halt` flag.

Two instruction groups are handled. Group 1 holds the clear, complement, increment, rotate and half-swap micro-operations. Group 2 holds the conditional skips, the accumulator clear, the panel-switch OR and halt. Several micro-operations can share one instruction word. They always take effect in a fixed order, so one word can build a whole short sequence. The extended-arithmetic group, any other major opcode and any cycle without `fire` leave the register untouched.

Top module: `opr_micro_unit`

## Requirements
- R1: A synchronous `rst` clears the accumulator, the link, `skip` and `halt`.
- R2: A word is executed only when `fire` is high and bits 11:9 equal 7. Bit 8 clear selects Group 1. Bit 8 set with bit 0 clear selects Group 2. Any other word, and any cycle without `fire`, leaves the accumulator and link unchanged and gives no skip.
- R3: In Group 1, bit 7 clears the accumulator and bit 6 clears the link first. Then bit 5 complements the accumulator and bit 4 complements the link, acting on the cleared values.
- R4: In Group 1, bit 0 then increments the whole 13-bit link:accumulator value, wrapping at 2^13. A carry out of the accumulator therefore toggles the link.
- R5: Last in Group 1, bits {3,2,1} act on the incremented value. 010 rotates link:accumulator left by one and 011 rotates it left by two. 100 rotates it right by one and 101 rotates it right by two. 001 swaps the two halves of the accumulator and keeps the link. 000 does nothing. 110 and 111 rotate left and then right by the same amount, leaving the value unchanged.
- R6: In Group 2 three skip tests are ORed: bit 6 (accumulator MSB set), bit 5 (accumulator zero) and bit 4 (link set). The tests use the accumulator value from before the word's clear. Bit 3 inverts the combined result. With no test bits set, the word skips only when bit 3 is set.
- R7: In Group 2, after the skip test, bit 7 clears the accumulator and then bit 2 ORs `panel_sw` into it. The link is never changed by Group 2.
- R8: A Group 2 word with bit 1 set sets `halt`. `halt` then stays set until reset.
- R9: `skip` is high only in the cycle that follows a Group 2 execution whose skip result is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fire | input | 1 | Execute strobe for `op_word` |
| op_word | input | 12 | Instruction word |
| panel_sw | input | WORD_W | Switch-register value for the OR step |
| acc | output | WORD_W | Accumulator |
| link | output | 1 | Link bit |
| skip | output | 1 | Skip result of the previous cycle's Group 2 word |
| halt | output | 1 | Sticky halt flag |

## Verification
The bench builds the block with the default 12-bit word. At that width the low byte of a Group 1 word has 256 values and the control field of a Group 2 word has 128, so both are swept completely. Each pattern runs against several accumulator seeds and both link values, with the results predicted by integer arithmetic in the bench. The narrow word also means the carry into the link, the MSB test and the zero test are all reached from the seeds. Directed cases add the ignored groups, the one-cycle skip pulse and the sticky halt.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int INSTR_W = 12;
  localparam logic [2:0] OPR_MAJOR = 3'b111;

  // Group 1 control field, instruction bits 7..0
  typedef struct packed {
    logic cla;    // clear accumulator
    logic cll;    // clear link
    logic cma;    // complement accumulator
    logic cml;    // complement link
    logic rgt;    // rotate right
    logic lft;    // rotate left
    logic dbl;    // twice / half swap
    logic inc;    // increment link:acc
  } g1_ctl_t;

  // Group 2 control field, instruction bits 7..1
  typedef struct packed {
    logic cla;    // clear accumulator
    logic neg;    // test acc MSB
    logic zro;    // test acc zero
    logic lnk;    // test link
    logic inv;    // invert skip sense
    logic orsw;   // OR switches
    logic hlt;    // halt
  } g2_ctl_t;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic       fire,
  input  logic [2:0] major,
  input  logic       grp_sel,
  input  logic       low_bit,
  output logic       g1_fire,
  output logic       g2_fire
);
  logic is_opr;

  always_comb begin
    is_opr  = fire && (major == OPR_MAJOR);
    g1_fire = is_opr && !grp_sel;
    g2_fire = is_opr && grp_sel && !low_bit;
  end
endmodule

// File: rtl/opr_group1.sv
module opr_group1
  import opr_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              link_i,
  input  logic [WORD_W-1:0] acc_i,
  input  g1_ctl_t           ctl,
  output logic              link_o,
  output logic [WORD_W-1:0] acc_o
);
  localparam int LW   = WORD_W + 1;
  localparam int HALF = WORD_W / 2;

  typedef logic [LW-1:0] lac_t;

  function automatic lac_t rot_l(input lac_t v);
    return {v[LW-2:0], v[LW-1]};
  endfunction

  function automatic lac_t rot_r(input lac_t v);
    return {v[0], v[LW-1:1]};
  endfunction

  function automatic lac_t swap_halves(input lac_t v);
    return {v[LW-1], v[HALF-1:0], v[WORD_W-1:HALF]};
  endfunction

  function automatic lac_t bump(input lac_t v);
    return v + lac_t'(1);
  endfunction

  lac_t step0, step1, step2, step3, step4;

  always_comb begin
    step0 = {link_i, acc_i};

    // step 1: clears
    step1 = step0;
    if (ctl.cla) step1[WORD_W-1:0] = '0;
    if (ctl.cll) step1[WORD_W]     = 1'b0;

    // step 2: complements
    step2 = step1;
    if (ctl.cml) step2[WORD_W]     = ~step1[WORD_W];
    if (ctl.cma) step2[WORD_W-1:0] = ~step1[WORD_W-1:0];

    // step 3: increment across link and accumulator
    step3 = ctl.inc ? bump(step2) : step2;

    // step 4: rotate or swap
    unique case ({ctl.rgt, ctl.lft, ctl.dbl})
      3'b010:  step4 = rot_l(step3);
      3'b011:  step4 = rot_l(rot_l(step3));
      3'b100:  step4 = rot_r(step3);
      3'b101:  step4 = rot_r(rot_r(step3));
      3'b001:  step4 = swap_halves(step3);
      3'b110:  step4 = rot_r(rot_l(step3));
      3'b111:  step4 = rot_r(rot_r(rot_l(rot_l(step3))));
      default: step4 = step3;
    endcase

    link_o = step4[WORD_W];
    acc_o  = step4[WORD_W-1:0];
  end
endmodule

// File: rtl/opr_group2.sv
module opr_group2
  import opr_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              link_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] sw_i,
  input  g2_ctl_t           ctl,
  output logic [WORD_W-1:0] acc_o,
  output logic              cond_o,
  output logic              skip_o,
  output logic              halt_o
);
  logic [WORD_W-1:0] acc_clr;

  always_comb begin
    // skip test on the incoming accumulator, before any clear
    cond_o = (ctl.neg && acc_i[WORD_W-1])
           | (ctl.zro && (acc_i == '0))
           | (ctl.lnk && link_i);
    skip_o = cond_o ^ ctl.inv;

    acc_clr = ctl.cla  ? '0 : acc_i;
    acc_o   = ctl.orsw ? (acc_clr | sw_i) : acc_clr;
    halt_o  = ctl.hlt;
  end
endmodule

// File: rtl/opr_micro_unit.sv
module opr_micro_unit
  import opr_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic [INSTR_W-1:0]  op_word,
  input  logic [WORD_W-1:0]   panel_sw,
  output logic [WORD_W-1:0]   acc,
  output logic                link,
  output logic                skip,
  output logic                halt
);
  logic              g1_fire, g2_fire;
  logic              g1_link;
  logic [WORD_W-1:0] g1_acc, g2_acc;
  logic              g2_cond, g2_skip, g2_halt;

  logic [WORD_W-1:0] acc_q;
  logic              link_q, skip_q, halt_q;

  opr_decode u_dec (
    .fire    (fire),
    .major   (op_word[11:9]),
    .grp_sel (op_word[8]),
    .low_bit (op_word[0]),
    .g1_fire (g1_fire),
    .g2_fire (g2_fire)
  );

  opr_group1 #(.WORD_W(WORD_W)) u_g1 (
    .link_i (link_q),
    .acc_i  (acc_q),
    .ctl    (g1_ctl_t'(op_word[7:0])),
    .link_o (g1_link),
    .acc_o  (g1_acc)
  );

  opr_group2 #(.WORD_W(WORD_W)) u_g2 (
    .link_i (link_q),
    .acc_i  (acc_q),
    .sw_i   (panel_sw),
    .ctl    (g2_ctl_t'(op_word[7:1])),
    .acc_o  (g2_acc),
    .cond_o (g2_cond),
    .skip_o (g2_skip),
    .halt_o (g2_halt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      link_q <= 1'b0;
      skip_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      skip_q <= 1'b0;
      if (g1_fire) begin
        acc_q  <= g1_acc;
        link_q <= g1_link;
      end else if (g2_fire) begin
        acc_q  <= g2_acc;
        skip_q <= g2_skip;
        if (g2_halt) halt_q <= 1'b1;
      end
    end
  end

  assign acc  = acc_q;
  assign link = link_q;
  assign skip = skip_q;
  assign halt = halt_q;

  // R2: words that are not executed leave state alone and give no skip
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(g1_fire || g2_fire) |=> ($stable(acc_q) && $stable(link_q) && !skip_q));

  // R7: Group 2 never touches the link
  assert_g2_link_kept_R7: assert property (@(posedge clk) disable iff (rst)
    g2_fire |=> $stable(link_q));

  // R6: a Group 2 word with no tests and no inversion never skips
  assert_no_test_no_skip_R6: assert property (@(posedge clk) disable iff (rst)
    (g2_fire && (op_word[6:3] == 4'b0000)) |=> !skip_q);

  // R6: a true test without inversion always skips
  assert_cond_skips_R6: assert property (@(posedge clk) disable iff (rst)
    (g2_fire && g2_cond && !op_word[3]) |=> skip_q);

  // R8: halt is sticky
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q);

  // R8: halt only rises after a Group 2 halt word
  assert_halt_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_q) |-> $past(g2_fire && g2_halt));

  // R9: a skip pulse always follows a Group 2 execution
  assert_skip_source_R9: assert property (@(posedge clk) disable iff (rst)
    skip_q |-> $past(g2_fire));
endmodule

// File: tb/opr_micro_unit_test.sv
`timescale 1ns/1ps
module opr_micro_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        fire;
  logic [11:0] op_word;
  logic [11:0] panel_sw;
  logic [11:0] acc;
  logic        link, skip, halt;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  opr_micro_unit uut (
    .clk(clk), .rst(rst), .fire(fire), .op_word(op_word),
    .panel_sw(panel_sw), .acc(acc), .link(link), .skip(skip), .halt(halt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [11:0] w, input logic [11:0] s);
    @(negedge clk);
    fire = 1'b1; op_word = w; panel_sw = s;
    @(negedge clk);
    fire = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic load(input int a, input int l);
    do_op(12'o7604, 12'(a));      // Group 2: clear, OR switches
    do_op(12'o7100, 12'o0);       // Group 1: clear link
    if (l != 0) do_op(12'o7020, 12'o0);  // Group 1: complement link
  endtask

  function automatic int lac_now();
    return (int'(link) << 12) | int'(acc);
  endfunction

  function automatic int rl(input int v, input int n);
    return ((v << n) | (v >> (13 - n))) & 'o17777;
  endfunction

  function automatic int rr(input int v, input int n);
    return ((v >> n) | (v << (13 - n))) & 'o17777;
  endfunction

  // reference for Group 1, b = low byte of the word
  function automatic int ref_g1(input int v0, input int b);
    int v = v0;
    if ((b & 'o200) != 0) v = v & 'o10000;
    if ((b & 'o100) != 0) v = v & 'o7777;
    if ((b & 'o020) != 0) v = v ^ 'o10000;
    if ((b & 'o040) != 0) v = v ^ 'o7777;
    if ((b & 'o001) != 0) v = (v + 1) % 8192;
    case ((b >> 1) & 7)
      1: v = (v & 'o10000) | ((v & 'o77) << 6) | ((v >> 6) & 'o77);
      2: v = rl(v, 1);
      3: v = rl(v, 2);
      4: v = rr(v, 1);
      5: v = rr(v, 2);
      6: v = rr(rl(v, 1), 1);
      7: v = rr(rl(v, 2), 2);
      default: ;
    endcase
    return v;
  endfunction

  function automatic int ref_g2_skip(input int v, input int b);
    bit c = 1'b0;
    if ((b & 'o100) != 0 && (v & 'o4000) != 0) c = 1'b1;
    if ((b & 'o040) != 0 && (v & 'o7777) == 0) c = 1'b1;
    if ((b & 'o020) != 0 && (v & 'o10000) != 0) c = 1'b1;
    if ((b & 'o010) != 0) c = !c;
    return int'(c);
  endfunction

  function automatic int ref_g2_acc(input int v, input int b, input int s);
    int a = v & 'o7777;
    if ((b & 'o200) != 0) a = 0;
    if ((b & 'o004) != 0) a = a | s;
    return a;
  endfunction

  int seeds [8] = '{'o0000, 'o7777, 'o4000, 'o0001, 'o5252, 'o2525, 'o7776, 'o0077};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; fire = 1'b0; op_word = '0; panel_sw = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset lac", lac_now(), 0);
    check("R1", "reset skip/halt", {skip, halt}, 0);
    rst = 1'b0;

    // R3 clear then complement gives all ones
    load('o1234, 1);
    do_op(12'o7360, 0);
    check("R3", "cla cll cma cml", lac_now(), 'o17777);

    // R4 carry from accumulator into link
    load('o7777, 0);
    do_op(12'o7001, 0);
    check("R4", "iac carry", lac_now(), 'o10000);

    // R5 rotate left through link and half swap
    load('o4000, 0);
    do_op(12'o7004, 0);
    check("R5", "ral", lac_now(), 'o10000);
    load('o0102, 1);
    do_op(12'o7002, 0);
    check("R5", "swap", lac_now(), 'o10201);

    // R6 zero test uses accumulator before clear
    load('o0005, 0);
    do_op(12'o7640, 0);
    check("R6", "sza pre-clear skip", int'(skip), 0);
    check("R7", "cla result", int'(acc), 0);
    do_op(12'o7440, 0);
    check("R6", "sza on zero", int'(skip), 1);
    // R9 pulse lasts one cycle
    @(negedge clk);
    check("R9", "skip drops", int'(skip), 0);

    // R7 OR of switches after clear, link kept
    load('o0070, 1);
    do_op(12'o7404, 'o4001);
    check("R7", "osr no clear", lac_now(), 'o14071);

    // R2 ignored words
    load('o1234, 1);
    do_op(12'o7601, 0);
    check("R2", "group3 ignored", lac_now(), 'o11234);
    check("R2", "group3 no skip", int'(skip), 0);
    do_op(12'o1200, 0);
    check("R2", "other major ignored", lac_now(), 'o11234);
    @(negedge clk); op_word = 12'o7200; fire = 1'b0;
    @(negedge clk);
    check("R2", "no fire ignored", lac_now(), 'o11234);

    // R8 halt sticky until reset
    do_op(12'o7402, 0);
    check("R8", "halt set", int'(halt), 1);
    do_op(12'o7200, 0);
    do_op(12'o7410, 0);
    check("R8", "halt held", int'(halt), 1);
    do_reset();
    check("R1", "halt cleared by reset", int'(halt), 0);

    // R3 R4 R5 exhaustive Group 1 sweep
    foreach (seeds[k]) begin
      for (int l = 0; l < 2; l++) begin
        for (int b = 0; b < 256; b++) begin
          int v0, exp;
          load(seeds[k], l);
          v0  = (l << 12) | seeds[k];
          exp = ref_g1(v0, b);
          do_op(12'(('o7000) | b), 0);
          check("R3 R4 R5", $sformatf("g1 b=%0o v=%0o", b, v0), lac_now(), exp);
          check("R9", "g1 no skip", int'(skip), 0);
        end
      end
    end

    // R6 R7 R8 exhaustive Group 2 sweep
    foreach (seeds[k]) begin
      for (int l = 0; l < 2; l++) begin
        for (int c = 0; c < 128; c++) begin
          int v0, b, s;
          b  = c << 1;
          s  = 'o1234 ^ seeds[k];
          load(seeds[k], l);
          v0 = (l << 12) | seeds[k];
          do_op(12'(('o7400) | b), 12'(s));
          check("R6", $sformatf("g2 skip b=%0o v=%0o", b, v0), int'(skip), ref_g2_skip(v0, b));
          check("R7", $sformatf("g2 lac b=%0o v=%0o", b, v0), lac_now(),
                (l << 12) | ref_g2_acc(v0, b, s));
          check("R8", $sformatf("g2 halt b=%0o", b), int'(halt), (b >> 1) & 1);
          if (halt) do_reset();
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule